// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block brings a two-wire serial bus that may be stuck back to a clean idle state. A peripheral can be left mid-byte and hold the data line low. When software or a higher-level controller pulses the start input, the sequencer first lets go of both open-drain lines. It then clocks the bus nine times, releasing the clock line after each low phase and waiting for it to actually read high, because a peripheral may stretch it. On each of those rises it notes whether the data line was released.

If the data line read high at least once, the sequencer checks that both lines rest high. It then produces a START followed at once by a STOP. It makes this pair by moving only the data line while the clock line stays released, so no peripheral sees an extra clock edge. After that it leaves the bus untouched for a bus-free interval and reports completion.

If the data line never read high, no START/STOP is produced and the result is a failure. A clock line that stays held low past a stretch limit also ends the sequence with a failure. The lines are driven low only through enable outputs. The pins themselves are read back through the two inputs.

Top module: `bus_recover_seq`

## Requirements
- R1: After reset, and whenever no recovery is running, both drive enables are 0 and done, fail and warn are 0. The only exception is fail and warn keeping their last result (R10).
- R2: A 1 on startPulse while idle starts exactly nine clock pulses. Each pulse drives the clock line low for HALF_CYCLES cycles, beginning the cycle after the start edge. It then releases the line, and keeps it released for HALF_CYCLES cycles counted from the edge at which sclIn first reads 1.
- R3: The data line is sampled at the edge where the released clock line first reads 1, and the samples are ORed into one flag. All nine pulses are produced even when the data line reads 1 from the first pulse on.
- R4: If no sample read 1, the data line is never driven. done is 1 for exactly one cycle, directly after the ninth high phase, with fail = 1.
- R5: If a sample read 1, warn is set to 1 exactly when sclIn or sdaIn reads 0 at the edge that ends the ninth high phase. Otherwise warn is 0.
- R6: After a successful clocking phase, the data line stays released for GAP_CYCLES cycles, is driven low for GAP_CYCLES cycles, and is then released. The clock enable stays 0 throughout.
- R7: After the data line is released, both lines stay undriven for FREE_CYCLES cycles. done is then 1 for one cycle with fail = 0.
- R8: If sclIn still reads 0 at STRETCH_CYCLES consecutive edges after a clock release, the sequence stops. No START/STOP is made, and done is 1 in the following cycle with fail = 1. If sclIn reads 1 at the last permitted edge, the rise counts and the sequence goes on.
- R9: startPulse has no effect while a recovery is running, including the cycle in which done is 1.
- R10: fail and warn keep their value after done until the next accepted start, which clears both at that start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Request a recovery (accepted only when idle) |
| sclIn | input | 1 | Level read back from the clock pin |
| sdaIn | input | 1 | Level read back from the data pin |
| sclDrvLow | output | 1 | 1 pulls the clock pin low, 0 releases it |
| sdaDrvLow | output | 1 | 1 pulls the data pin low, 0 releases it |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result: 1 means recovery failed (valid with done, held after) |
| warn | output | 1 | Result: 1 means lines were not both high before START/STOP |

## Verification
The sharpest same-cycle case is a clock line that finally rises on the very edge at which the stretch limit runs out. At that one edge the rise and the timeout compete. The bench provokes it by holding the clock line low for one edge fewer than the limit, and then for exactly the limit. It judges the outcome from fail, from the number of clock pulses, and from a cycle-accurate behavioural model. A second collision is a new start request arriving in the same cycle as the done pulse, or in the middle of a run. It is judged by checking that no new clock pulse follows.

// File: rtl/busrec_pkg.sv
`timescale 1ns/1ps
package busrec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_RISE,
    ST_HIGH,
    ST_SETUP,
    ST_PULL,
    ST_FREE,
    ST_DONE
  } recState_t;

  typedef enum logic [2:0] {
    LD_NONE,
    LD_HALF,
    LD_STRETCH,
    LD_GAP,
    LD_FREE
  } timerLoad_t;

  typedef struct packed {
    timerLoad_t load;        // reload of the shared countdown
    logic       clearFlags;  // new run: clear pulse count and results
    logic       takeSample;  // clock rise seen: count pulse, OR in data
    logic       checkIdle;   // before START: record whether lines rest high
    logic       markFail;    // end of run with failure
  } recStrobe_t;

endpackage

// File: rtl/busrec_dpath.sv
`timescale 1ns/1ps
module busrec_dpath
  import busrec_pkg::*;
#(
  parameter int HALF_CYCLES    = 250,
  parameter int GAP_CYCLES     = 125,
  parameter int FREE_CYCLES    = 7500,
  parameter int STRETCH_CYCLES = 125000,
  parameter int PULSE_COUNT    = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  recStrobe_t strb,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       timerZero,
  output logic       pulsesDone,
  output logic       wasHigh,
  output logic       fail,
  output logic       warn
);

  localparam int LongA   = (HALF_CYCLES > GAP_CYCLES) ? HALF_CYCLES : GAP_CYCLES;
  localparam int LongB   = (FREE_CYCLES > STRETCH_CYCLES) ? FREE_CYCLES : STRETCH_CYCLES;
  localparam int Longest = (LongA > LongB) ? LongA : LongB;
  localparam int TimerW  = $clog2(Longest + 1);
  localparam int PcntW   = $clog2(PULSE_COUNT + 1);

  logic [TimerW-1:0] timer;
  logic [PcntW-1:0]  pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else begin
      case (strb.load)
        LD_HALF:    timer <= TimerW'(HALF_CYCLES - 1);
        LD_STRETCH: timer <= TimerW'(STRETCH_CYCLES - 1);
        LD_GAP:     timer <= TimerW'(GAP_CYCLES - 1);
        LD_FREE:    timer <= TimerW'(FREE_CYCLES - 1);
        default:    if (timer != '0) timer <= timer - 1'b1;
      endcase
    end
  end

  assign timerZero = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      wasHigh  <= 1'b0;
    end else if (strb.clearFlags) begin
      pulseCnt <= '0;
      wasHigh  <= 1'b0;
    end else if (strb.takeSample) begin
      pulseCnt <= pulseCnt + 1'b1;
      wasHigh  <= wasHigh | sdaIn;
    end
  end

  assign pulsesDone = (pulseCnt == PcntW'(PULSE_COUNT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail <= 1'b0;
      warn <= 1'b0;
    end else if (strb.clearFlags) begin
      fail <= 1'b0;
      warn <= 1'b0;
    end else begin
      if (strb.markFail)  fail <= 1'b1;
      if (strb.checkIdle) warn <= !(sclIn && sdaIn);
    end
  end

  // R2
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PcntW'(PULSE_COUNT));

  // R3
  was_high_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wasHigh && !strb.clearFlags) |=> wasHigh);

  // R10
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strb.clearFlags) |=> fail);

endmodule

// File: rtl/busrec_ctrl.sv
`timescale 1ns/1ps
module busrec_ctrl
  import busrec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       sclIn,
  input  logic       timerZero,
  input  logic       pulsesDone,
  input  logic       wasHigh,
  output recStrobe_t strb,
  output logic       sclDrvLow,
  output logic       sdaDrvLow,
  output logic       done
);

  recState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '{load: LD_NONE, default: 1'b0};
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.clearFlags = 1'b1;
          strb.load       = LD_HALF;
          nextState       = ST_LOW;
        end
      end
      ST_LOW: begin
        if (timerZero) begin
          strb.load = LD_STRETCH;
          nextState = ST_RISE;
        end
      end
      ST_RISE: begin
        if (sclIn) begin
          strb.takeSample = 1'b1;
          strb.load       = LD_HALF;
          nextState       = ST_HIGH;
        end else if (timerZero) begin
          strb.markFail = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_HIGH: begin
        if (timerZero) begin
          if (!pulsesDone) begin
            strb.load = LD_HALF;
            nextState = ST_LOW;
          end else if (wasHigh) begin
            strb.checkIdle = 1'b1;
            strb.load      = LD_GAP;
            nextState      = ST_SETUP;
          end else begin
            strb.markFail = 1'b1;
            nextState     = ST_DONE;
          end
        end
      end
      ST_SETUP: begin
        if (timerZero) begin
          strb.load = LD_GAP;
          nextState = ST_PULL;
        end
      end
      ST_PULL: begin
        if (timerZero) begin
          strb.load = LD_FREE;
          nextState = ST_FREE;
        end
      end
      ST_FREE: begin
        if (timerZero) nextState = ST_DONE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign sclDrvLow = (state == ST_LOW);
  assign sdaDrvLow = (state == ST_PULL);
  assign done      = (state == ST_DONE);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && startPulse) |-> !strb.clearFlags);

endmodule

// File: rtl/bus_recover_seq.sv
`timescale 1ns/1ps
module bus_recover_seq
  import busrec_pkg::*;
#(
  parameter int HALF_CYCLES    = 250,
  parameter int GAP_CYCLES     = 125,
  parameter int FREE_CYCLES    = 7500,
  parameter int STRETCH_CYCLES = 125000,
  parameter int PULSE_COUNT    = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic startPulse,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclDrvLow,
  output logic sdaDrvLow,
  output logic done,
  output logic fail,
  output logic warn
);

  recStrobe_t strb;
  logic       timerZero;
  logic       pulsesDone;
  logic       wasHigh;

  busrec_ctrl ctrlI (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .sclIn      (sclIn),
    .timerZero  (timerZero),
    .pulsesDone (pulsesDone),
    .wasHigh    (wasHigh),
    .strb       (strb),
    .sclDrvLow  (sclDrvLow),
    .sdaDrvLow  (sdaDrvLow),
    .done       (done)
  );

  busrec_dpath #(
    .HALF_CYCLES    (HALF_CYCLES),
    .GAP_CYCLES     (GAP_CYCLES),
    .FREE_CYCLES    (FREE_CYCLES),
    .STRETCH_CYCLES (STRETCH_CYCLES),
    .PULSE_COUNT    (PULSE_COUNT)
  ) dpathI (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .timerZero  (timerZero),
    .pulsesDone (pulsesDone),
    .wasHigh    (wasHigh),
    .fail       (fail),
    .warn       (warn)
  );

  // R1
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!sclDrvLow && !sdaDrvLow && !done));

  // R4
  fail_no_sda_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail) |-> !$past(sdaDrvLow));

  // R7
  ok_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fail) |-> $past(!sclDrvLow && !sdaDrvLow));

  // R8
  timeout_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlI.state == ST_RISE && !sclIn && timerZero) |=> (done && fail));

endmodule

// File: tb/bus_recover_seq_tb_top.sv
`timescale 1ns/1ps
module bus_recover_seq_tb_top;

  localparam int Half    = 4;
  localparam int Gap     = 3;
  localparam int Free    = 10;
  localparam int Stretch = 6;
  localparam int Pulses  = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic sclHold = 1'b0;
  logic sdaHold = 1'b0;
  wire  sclDrvLow, sdaDrvLow, done, fail, warn;
  wire  sclIn = ~(sclDrvLow | sclHold);
  wire  sdaIn = ~(sdaDrvLow | sdaHold);

  int errors = 0;
  int checks = 0;
  int stretchLen = 0;
  int holdLeft = 0;
  int lowPulses = 0;
  int sdaCycles = 0;
  int overlap = 0;
  logic prevDrv = 1'b0;

  always #4 clk = ~clk;

  bus_recover_seq #(
    .HALF_CYCLES(Half), .GAP_CYCLES(Gap), .FREE_CYCLES(Free),
    .STRETCH_CYCLES(Stretch), .PULSE_COUNT(Pulses)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .done(done), .fail(fail), .warn(warn)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Slow peripheral: keeps the clock line low for stretchLen edges after each release.
  always @(negedge clk) begin
    if (sclDrvLow) begin
      holdLeft = stretchLen;
      sclHold  = 1'b0;
    end else begin
      sclHold = (holdLeft > 0);
      if (holdLeft > 0) holdLeft--;
    end
  end

  // Activity counters.
  always @(negedge clk) begin
    if (sclDrvLow && !prevDrv) lowPulses++;
    if (sdaDrvLow) sdaCycles++;
    if (sdaDrvLow && sclDrvLow) overlap++;
    prevDrv = sclDrvLow;
  end

  // Behavioural reference: phase name plus cycles remaining.
  string mPhase = "idle";
  int    mLeft = 0, mWaited = 0, mRises = 0;
  bit    mSeen = 0, mFail = 0, mWarn = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = "idle"; mFail = 0; mWarn = 0; mSeen = 0; mRises = 0;
    end else if (mPhase == "idle") begin
      if (startPulse) begin
        mPhase = "low"; mLeft = Half; mRises = 0; mSeen = 0; mFail = 0; mWarn = 0;
      end
    end else if (mPhase == "low") begin
      if (mLeft == 1) begin mPhase = "rise"; mWaited = 0; end
      else mLeft--;
    end else if (mPhase == "rise") begin
      if (sclIn) begin
        mSeen = mSeen | sdaIn; mRises++; mPhase = "high"; mLeft = Half;
      end else if (mWaited + 1 == Stretch) begin
        mFail = 1; mPhase = "done";
      end else mWaited++;
    end else if (mPhase == "high") begin
      if (mLeft > 1) mLeft--;
      else if (mRises < Pulses) begin mPhase = "low"; mLeft = Half; end
      else if (mSeen) begin
        mWarn = !(sclIn && sdaIn); mPhase = "setup"; mLeft = Gap;
      end else begin mFail = 1; mPhase = "done"; end
    end else if (mPhase == "setup") begin
      if (mLeft == 1) begin mPhase = "pull"; mLeft = Gap; end else mLeft--;
    end else if (mPhase == "pull") begin
      if (mLeft == 1) begin mPhase = "free"; mLeft = Free; end else mLeft--;
    end else if (mPhase == "free") begin
      if (mLeft == 1) mPhase = "done"; else mLeft--;
    end else begin
      mPhase = "idle";
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(sclDrvLow == (mPhase == "low"), "R2", "model sclDrvLow", sclDrvLow, mPhase == "low");
      check(sdaDrvLow == (mPhase == "pull"), "R6", "model sdaDrvLow", sdaDrvLow, mPhase == "pull");
      check(done == (mPhase == "done"), "R7", "model done", done, mPhase == "done");
      check(fail == mFail, "R4", "model fail", fail, mFail);
      check(warn == mWarn, "R5", "model warn", warn, mWarn);
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: cycles=%0d expected<%0d", 100000, 100000);
    finishRun();
  end

  task automatic runRecovery(input int midDelay, input bit startAtDone);
    int guard = 0;
    lowPulses = 0; sdaCycles = 0; overlap = 0;
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    check(sclDrvLow == 1'b1, "R2", "first low after start", sclDrvLow, 1);
    check(fail == 1'b0 && warn == 1'b0, "R10", "results cleared by start", {fail, warn}, 0);
    if (midDelay > 0) begin
      repeat (midDelay) @(negedge clk);
      startPulse = 1'b1;
      @(negedge clk) startPulse = 1'b0;
    end
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (startAtDone) begin
      startPulse = 1'b1;
      @(negedge clk) startPulse = 1'b0;
      for (int i = 0; i < 3; i++) begin
        check(sclDrvLow == 1'b0, "R9", "start in done cycle ignored", sclDrvLow, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!sclDrvLow && !sdaDrvLow && !done && !fail && !warn, "R1", "outputs in reset",
          {sclDrvLow, sdaDrvLow, done, fail, warn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!sclDrvLow && !sdaDrvLow && !done && !fail && !warn, "R1", "idle after reset",
          {sclDrvLow, sdaDrvLow, done, fail, warn}, 0);

    // Clean bus: data line high from the first pulse.
    runRecovery(0, 0);
    check(lowPulses == 9, "R3", "all nine pulses with data high", lowPulses, 9);
    check(fail == 0 && warn == 0, "R7", "clean success", {fail, warn}, 0);
    check(sdaCycles == Gap, "R6", "data drive length", sdaCycles, Gap);
    check(overlap == 0, "R6", "clock driven during data drive", overlap, 0);

    // Data stuck low throughout.
    sdaHold = 1'b1;
    runRecovery(0, 0);
    check(fail == 1, "R4", "stuck data fails", fail, 1);
    check(sdaCycles == 0, "R4", "no data drive on failure", sdaCycles, 0);
    check(lowPulses == 9, "R2", "pulse count on failure", lowPulses, 9);
    repeat (5) @(negedge clk);
    check(fail == 1, "R10", "fail held after done", fail, 1);

    // Data released after the fifth pulse.
    fork
      runRecovery(0, 0);
      begin
        repeat (5) @(posedge sclIn);
        @(negedge clk) sdaHold = 1'b0;
      end
    join
    check(fail == 0, "R3", "late high sample recovers", fail, 0);

    // Data pulled low during the ninth high phase: warning.
    fork
      runRecovery(0, 0);
      begin
        repeat (9) @(posedge sclIn);
        @(negedge clk) sdaHold = 1'b1;
      end
    join
    check(warn == 1 && fail == 0, "R5", "warn with success", {warn, fail}, 2);
    sdaHold = 1'b0;
    repeat (2) @(negedge clk);

    // Stretch one edge short of the limit: rise wins.
    stretchLen = Stretch - 1;
    runRecovery(0, 0);
    check(fail == 0, "R8", "rise at last edge", fail, 0);
    check(lowPulses == 9, "R8", "pulses with stretch", lowPulses, 9);

    // Stretch reaching the limit: timeout.
    stretchLen = Stretch;
    runRecovery(0, 0);
    check(fail == 1, "R8", "stretch timeout", fail, 1);
    check(lowPulses == 1, "R8", "abort after first pulse", lowPulses, 1);
    check(sdaCycles == 0, "R8", "no START after timeout", sdaCycles, 0);
    stretchLen = 0;

    // Start requests while busy and in the done cycle.
    runRecovery(20, 1);
    check(lowPulses == 9, "R9", "mid-run start ignored", lowPulses, 9);
    check(fail == 0, "R9", "result after ignored starts", fail, 0);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule